// File: doc/BRIEF.md
# Multi-Mode Serial Port Controller

A byte-wide serial port for a small controller subsystem. One control/status register chooses among four operating modes: a synchronous shift mode, where the port drives a bit clock on `txd` and moves data on the bidirectional data line, and three asynchronous modes that send and receive 8-bit or 9-bit character frames. Software reads and writes the register through a port with a write enable per bit. Transmission starts on a data write strobe. The last accepted receive byte is held on a read port. Hardware sets the interrupt flags, the received ninth bit and a sticky framing-error flag. Software clears them by writing zero.

The asynchronous modes count 16 ticks per bit, taken from one of two external tick inputs, and decide each received bit by a three-sample majority vote near mid-bit. An address-filter bit lets a receiver in a multi-drop network ignore data frames and wake only on address frames. The same bit lets it ignore 8-bit frames whose stop bit is bad. Register bit 7 is shared between the high mode bit and the framing-error flag. An external select input decides which of the two is accessed.

Top module: `sport_ctrl`

## Requirements
- R1: After reset every register bit and the framing-error flag read 0, `rx_byte` is 0, `txd` is 1 and `rxd_oe` is 0.
- R2: Register layout: bit0 receive flag, bit1 transmit flag, bit2 received ninth bit, bit3 transmit ninth bit, bit4 receive enable, bit5 address filter, bit6 mode low bit, bit7 mode high bit or framing error. Mode {bit7,bit6}: 00 shift, 01 8-bit async, 10 9-bit async on `tick_fix`, 11 9-bit async on `tick_var`. With `fe_sel`=1, bit 7 reads and writes the framing-error flag. With `fe_sel`=0, it reads and writes the mode high bit.
- R3: A received stop bit of 0 sets the framing-error flag. A later good frame leaves it set. Only a write of 0 clears it.
- R4: An async frame on `txd` is a 0 start bit, 8 data bits LSB first, in modes 10/11 the transmit-ninth bit, then a 1 stop bit. Each bit lasts 16 ticks and the idle line is 1. A `tx_wr` while a frame is in progress is ignored.
- R5: The transmit flag sets at the start of the stop bit in the async modes, and after the 8th bit clock in shift mode.
- R6: Async receive votes over three samples at ticks 7 to 9 of each bit, so a single-tick glitch has no effect. A start bit voted high is dropped and no flag is set.
- R7: In 9-bit modes the received ninth bit goes to bit2. In 8-bit mode the stop bit goes to bit2.
- R8: With the address filter set, a 9-bit frame whose ninth bit is 0 sets no receive flag and leaves `rx_byte` and bit2 unchanged. An 8-bit frame with a bad stop bit likewise sets no receive flag.
- R9: With receive enable 0, an async frame on `rxd_i` sets no flag and leaves `rx_byte` unchanged.
- R10: Shift-mode transmit: `txd` goes low then high once per bit, 8 times. Data is driven LSB first on `rxd_o`, changing while `txd` is low. `rxd_oe` is 1 during the transfer.
- R11: Shift-mode receive starts only when receive enable is 1 and the receive flag is 0. It samples `rxd_i` as `txd` rises, LSB first, then sets the receive flag and loads `rx_byte`. No new transfer starts while the receive flag stays 1.
- R12: Mode 10 advances only on `tick_fix`. Modes 01 and 11 advance only on `tick_var`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 8 | Per-bit write enable for the register |
| ctrl_wdata | input | 8 | Register write data |
| fe_sel | input | 1 | Selects framing error (1) or mode high bit (0) at bit 7 |
| ctrl_rdata | output | 8 | Register read data |
| tx_wr | input | 1 | Transmit data write strobe |
| tx_byte | input | 8 | Data to transmit |
| rx_byte | output | 8 | Last accepted received byte |
| tick_var | input | 1 | 16x tick for modes 01 and 11 |
| tick_fix | input | 1 | 16x tick for mode 10 |
| tick_shift | input | 1 | Half-bit tick for shift mode |
| txd | output | 1 | Serial out (async) or bit clock (shift mode) |
| rxd_i | input | 1 | Data line input |
| rxd_o | output | 1 | Data line output value in shift mode |
| rxd_oe | output | 1 | Data line output enable |

## Verification
A wrong bit counter or mode decode in the transmitter shows on `txd` within one bit time. The line either holds a start bit too long or puts the ninth bit where a stop should be, and mid-bit sampling of the whole frame catches this. A fault in the receive vote, the ninth-bit capture or the address filter appears in the register flags and `rx_byte` at mid-stop of the same frame. A framing-error flag that is not sticky, or a wrong bit-7 alias, appears on the next register read. In shift mode, a wrong edge order or bit order changes the byte captured at the rising edges of `txd` before the transfer ends.

// File: rtl/sport_pkg.sv
package sport_pkg;
  typedef enum logic [1:0] {
    MODE_SHIFT  = 2'b00,
    MODE_UART8  = 2'b01,
    MODE_UART9F = 2'b10,
    MODE_UART9V = 2'b11
  } mode_e;
endpackage

// File: rtl/sport_shift.sv
module sport_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_go,
  input  logic          rx_go,
  input  logic [DW-1:0] tx_data,
  input  logic          rxd_i,
  output logic          busy,
  output logic          is_rx,
  output logic          sclk,
  output logic          dout,
  output logic          tx_done,
  output logic          rx_done,
  output logic [DW-1:0] shreg
);
  localparam int CW = $clog2(2 * DW);
  localparam logic [CW-1:0] LAST = CW'(2 * DW - 1);

  logic [CW-1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      is_rx   <= 1'b0;
      phase   <= '0;
      sclk    <= 1'b1;
      dout    <= 1'b1;
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      shreg   <= '0;
    end else begin
      tx_done <= 1'b0;
      rx_done <= 1'b0;
      if (!busy) begin
        if (tx_go) begin
          busy  <= 1'b1;
          is_rx <= 1'b0;
          shreg <= tx_data;
          phase <= '0;
        end else if (rx_go) begin
          busy  <= 1'b1;
          is_rx <= 1'b1;
          phase <= '0;
        end
      end else if (tick) begin
        if (!phase[0]) begin
          sclk <= 1'b0;
          if (!is_rx) dout <= shreg[0];
        end else begin
          sclk  <= 1'b1;
          shreg <= {is_rx ? rxd_i : 1'b0, shreg[DW-1:1]};
        end
        phase <= phase + 1'b1;
        if (phase == LAST) begin
          busy    <= 1'b0;
          tx_done <= !is_rx;
          rx_done <= is_rx;
        end
      end
    end
  end

  // R10
  sclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy && !$past(busy) |-> sclk);
endmodule

// File: rtl/sport_atx.sv
module sport_atx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          go,
  input  logic          nine,
  input  logic          ninth,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          line,
  output logic          stop_pulse
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(FW + 1);
  localparam logic [CW-1:0] CEND = CW'(OVS - 1);

  logic [FW-1:0] frame;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx, last;

  assign line = frame[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      frame      <= '1;
      cnt        <= '0;
      idx        <= '0;
      last       <= '0;
      busy       <= 1'b0;
      stop_pulse <= 1'b0;
    end else begin
      stop_pulse <= 1'b0;
      if (!busy) begin
        if (go) begin
          frame <= {1'b1, nine ? ninth : 1'b1, data, 1'b0};
          busy  <= 1'b1;
          cnt   <= '0;
          idx   <= '0;
          last  <= nine ? IW'(FW - 1) : IW'(FW - 2);
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        if (cnt == CEND) begin
          frame <= {1'b1, frame[FW-1:1]};
          if (idx == last) busy <= 1'b0;
          else idx <= idx + 1'b1;
          stop_pulse <= (idx + IW'(1)) == last;
        end
      end
    end
  end

  // R4
  start_low_chk: assert property (@(posedge clk) disable iff (rst)
    go && !busy |=> busy && !line);
  // R5
  stop_high_chk: assert property (@(posedge clk) disable iff (rst)
    stop_pulse |-> line);
endmodule

// File: rtl/sport_arx.sv
module sport_arx #(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_i,
  output logic          busy,
  output logic          done,
  output logic          stop_bit,
  output logic          bit9,
  output logic [DW-1:0] data
);
  localparam int CW = $clog2(OVS);
  localparam int IW = $clog2(DW + 4);
  localparam logic [CW-1:0] S0   = CW'(OVS / 2 - 1);
  localparam logic [CW-1:0] S1   = CW'(OVS / 2);
  localparam logic [CW-1:0] S2   = CW'(OVS / 2 + 1);
  localparam logic [CW-1:0] CEND = CW'(OVS - 1);

  logic          sy1, sy2, smp_a, smp_b, vote;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx, last;

  assign vote = (smp_a & smp_b) | (smp_a & sy2) | (smp_b & sy2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1 <= 1'b1; sy2 <= 1'b1; smp_a <= 1'b1; smp_b <= 1'b1;
      cnt <= '0; idx <= '0; last <= '0;
      busy <= 1'b0; done <= 1'b0; stop_bit <= 1'b1; bit9 <= 1'b0;
      data <= '0;
    end else begin
      done <= 1'b0;
      sy1  <= rxd_i;
      sy2  <= sy1;
      if (!busy) begin
        if (en && !sy2) begin
          busy <= 1'b1;
          cnt  <= '0;
          idx  <= '0;
          last <= nine ? IW'(DW + 2) : IW'(DW + 1);
        end
      end else if (tick) begin
        cnt <= cnt + 1'b1;
        if (cnt == S0) smp_a <= sy2;
        if (cnt == S1) smp_b <= sy2;
        if (cnt == S2) begin
          if (idx == '0) begin
            if (vote) busy <= 1'b0;
          end else if (idx <= IW'(DW)) begin
            data <= {vote, data[DW-1:1]};
          end else if (idx == last) begin
            done     <= 1'b1;
            stop_bit <= vote;
            busy     <= 1'b0;
          end else begin
            bit9 <= vote;
          end
        end
        if (cnt == CEND) idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sport_ctrl.sv
module sport_ctrl
  import sport_pkg::*;
#(
  parameter int DW  = 8,
  parameter int OVS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [7:0]    ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  input  logic          fe_sel,
  output logic [7:0]    ctrl_rdata,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_byte,
  output logic [DW-1:0] rx_byte,
  input  logic          tick_var,
  input  logic          tick_fix,
  input  logic          tick_shift,
  output logic          txd,
  input  logic          rxd_i,
  output logic          rxd_o,
  output logic          rxd_oe
);
  logic  mhi, mlo, filt, ren, tb8, rb8, ti, ri, fe;
  mode_e mode;
  logic  is_shift, a_tick;

  logic          s_busy, s_is_rx, s_sclk, s_dout, s_tx_done, s_rx_done;
  logic [DW-1:0] s_shreg;
  logic          t_busy, t_line, t_stop;
  logic          r_busy, r_done, r_stop, r_bit9;
  logic [DW-1:0] r_data;
  logic          accept, rb8_new;

  assign mode     = mode_e'({mhi, mlo});
  assign is_shift = (mode == MODE_SHIFT);
  assign a_tick   = (mode == MODE_UART9F) ? tick_fix : tick_var;

  sport_shift #(.DW(DW)) u_shift (
    .clk(clk), .rst(rst), .tick(tick_shift),
    .tx_go(tx_wr && is_shift),
    .rx_go(ren && !ri && is_shift && !s_rx_done && !tx_wr),
    .tx_data(tx_byte), .rxd_i(rxd_i),
    .busy(s_busy), .is_rx(s_is_rx), .sclk(s_sclk), .dout(s_dout),
    .tx_done(s_tx_done), .rx_done(s_rx_done), .shreg(s_shreg)
  );

  sport_atx #(.DW(DW), .OVS(OVS)) u_atx (
    .clk(clk), .rst(rst), .tick(a_tick), .go(tx_wr && !is_shift),
    .nine(mode[1]), .ninth(tb8), .data(tx_byte),
    .busy(t_busy), .line(t_line), .stop_pulse(t_stop)
  );

  sport_arx #(.DW(DW), .OVS(OVS)) u_arx (
    .clk(clk), .rst(rst), .tick(a_tick), .en(ren && !is_shift),
    .nine(mode[1]), .rxd_i(rxd_i),
    .busy(r_busy), .done(r_done), .stop_bit(r_stop), .bit9(r_bit9), .data(r_data)
  );

  assign txd    = is_shift ? s_sclk : t_line;
  assign rxd_o  = s_dout;
  assign rxd_oe = is_shift && s_busy && !s_is_rx;

  assign accept  = mode[1] ? !(filt && !r_bit9) : !(filt && !r_stop);
  assign rb8_new = mode[1] ? r_bit9 : r_stop;

  assign ctrl_rdata = {fe_sel ? fe : mhi, mlo, filt, ren, tb8, rb8, ti, ri};

  always_ff @(posedge clk) begin
    if (rst) begin
      {mhi, mlo, filt, ren, tb8, rb8, ti, ri} <= '0;
      fe      <= 1'b0;
      rx_byte <= '0;
    end else begin
      if (ctrl_we[7]) begin
        if (fe_sel) fe <= ctrl_wdata[7];
        else        mhi <= ctrl_wdata[7];
      end
      if (ctrl_we[6]) mlo  <= ctrl_wdata[6];
      if (ctrl_we[5]) filt <= ctrl_wdata[5];
      if (ctrl_we[4]) ren  <= ctrl_wdata[4];
      if (ctrl_we[3]) tb8  <= ctrl_wdata[3];
      if (ctrl_we[2]) rb8  <= ctrl_wdata[2];
      if (ctrl_we[1]) ti   <= ctrl_wdata[1];
      if (ctrl_we[0]) ri   <= ctrl_wdata[0];
      // hardware events take priority over a same-cycle software write
      if (s_tx_done || t_stop) ti <= 1'b1;
      if (s_rx_done) begin
        ri      <= 1'b1;
        rx_byte <= s_shreg;
      end
      if (r_done) begin
        if (!r_stop) fe <= 1'b1;
        if (accept) begin
          ri      <= 1'b1;
          rb8     <= rb8_new;
          rx_byte <= r_data;
        end
      end
    end
  end

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> ({mhi, mlo, filt, ren, tb8, rb8, ti, ri} == 8'h00) && !fe);
  // R3
  fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    fe && !(ctrl_we[7] && fe_sel) |=> fe);
  // R9
  ren_off_chk: assert property (@(posedge clk) disable iff (rst)
    !ren && !is_shift && !r_busy |=> !r_busy);
  // R8
  addr_filter_chk: assert property (@(posedge clk) disable iff (rst)
    r_done && mode[1] && filt && !r_bit9 && !ri && !s_rx_done &&
    !(ctrl_we[0] && ctrl_wdata[0]) |=> !ri);
endmodule

// File: tb/tb_sport_ctrl.sv
module tb_sport_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic [7:0] ctrl_we = '0, ctrl_wdata = '0, ctrl_rdata;
  logic       fe_sel = 1'b0, tx_wr = 1'b0;
  logic [7:0] tx_byte = '0, rx_byte;
  logic       tick_var = 1'b1, tick_fix = 1'b1, tick_shift = 1'b1;
  logic       txd, rxd_i = 1'b1, rxd_o, rxd_oe;

  sport_ctrl dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .fe_sel(fe_sel), .ctrl_rdata(ctrl_rdata), .tx_wr(tx_wr), .tx_byte(tx_byte),
    .rx_byte(rx_byte), .tick_var(tick_var), .tick_fix(tick_fix),
    .tick_shift(tick_shift), .txd(txd), .rxd_i(rxd_i), .rxd_o(rxd_o), .rxd_oe(rxd_oe)
  );

  int total = 0, bad = 0;
  bit ended = 0;

  // fields: mode[16:15] filt[14] data[13:6] b9[5] stop[4] ri[3] rb8[2] fe[1] upd[0]
  localparam logic [16:0] VEC [9] = '{
    {2'd1, 1'b0, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd1, 1'b0, 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1},
    {2'd1, 1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {2'd1, 1'b1, 8'h81, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd3, 1'b0, 8'hC3, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd3, 1'b1, 8'h7E, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    {2'd3, 1'b1, 8'hE7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
    {2'd2, 1'b0, 8'h0F, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1},
    {2'd3, 1'b0, 8'h99, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] we, input logic [7:0] d, input logic sel);
    @(negedge clk);
    ctrl_we = we; ctrl_wdata = d; fe_sel = sel;
    @(negedge clk);
    ctrl_we = '0;
  endtask

  task automatic rd(input logic sel, output logic [7:0] v);
    fe_sel = sel;
    #1 v = ctrl_rdata;
  endtask

  task automatic send(input logic [7:0] d, input bit nine, input bit b9,
                      input bit stp, input bit glitch);
    @(negedge clk);
    rxd_i = 1'b0;
    repeat (16) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_i = d[i];
      if (glitch && i == 0) begin
        repeat (8) @(negedge clk);
        rxd_i = ~d[i];
        @(negedge clk);
        rxd_i = d[i];
        repeat (7) @(negedge clk);
      end else repeat (16) @(negedge clk);
    end
    if (nine) begin
      rxd_i = b9;
      repeat (16) @(negedge clk);
    end
    rxd_i = stp;
    repeat (16) @(negedge clk);
    rxd_i = 1'b1;
    repeat (24) @(negedge clk);
  endtask

  // captures nb bits at mid-bit and the transmit flag at each sample point
  task automatic txcap(input int nb, input bit poke,
                       output logic [10:0] bits, output logic [10:0] tiv);
    bits = '0; tiv = '0;
    @(negedge clk); tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (8) @(negedge clk);
    bits[0] = txd; tiv[0] = ctrl_rdata[1];
    for (int k = 1; k < nb; k++) begin
      if (poke && k == 2) begin
        tx_byte = 8'hFF; tx_wr = 1'b1;
        @(negedge clk); tx_wr = 1'b0;
        repeat (15) @(negedge clk);
      end else repeat (16) @(negedge clk);
      bits[k] = txd; tiv[k] = ctrl_rdata[1];
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [7:0]  exp_rx;
    logic [10:0] bits, tiv;
    logic [7:0]  got;
    int          n;
    bit          oe_ok, prev;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd(1'b1, v);
    chk(v == 8'h00, "R1 reg fe_sel=1", v, 0);
    rd(1'b0, v);
    chk(v == 8'h00, "R1 reg fe_sel=0", v, 0);
    chk(rx_byte == 8'h00 && txd && !rxd_oe, "R1 pins", {rx_byte, txd, rxd_oe}, 16'h0002);

    // vector walk: async reception (R3 R7 R8 R12 via mode 10)
    exp_rx = 8'h00;
    foreach (VEC[i]) begin
      logic [1:0] m;
      m = VEC[i][16:15];
      wr(8'hFF, {m, VEC[i][14], 1'b1, 4'b0000}, 1'b0);
      wr(8'h80, 8'h00, 1'b1);
      send(VEC[i][13:6], m[1], VEC[i][5], VEC[i][4], 1'b0);
      if (VEC[i][0]) exp_rx = VEC[i][13:6];
      rd(1'b1, v);
      chk(v[0] == VEC[i][3], $sformatf("R8 vec%0d receive flag", i), v[0], VEC[i][3]);
      chk(v[2] == VEC[i][2], $sformatf("R7 vec%0d ninth bit", i), v[2], VEC[i][2]);
      chk(v[7] == VEC[i][1], $sformatf("R3 vec%0d framing", i), v[7], VEC[i][1]);
      chk(rx_byte == exp_rx, $sformatf("R8 vec%0d data", i), rx_byte, exp_rx);
    end

    // R3 sticky framing error
    wr(8'hFF, 8'h50, 1'b0);
    wr(8'h80, 8'h00, 1'b1);
    send(8'h12, 1'b0, 1'b0, 1'b0, 1'b0);
    send(8'h34, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(1'b1, v);
    chk(v[7] == 1'b1 && rx_byte == 8'h34, "R3 stays set after good frame", {v[7], rx_byte}, 9'h134);
    wr(8'h80, 8'h00, 1'b1);
    rd(1'b1, v);
    chk(v[7] == 1'b0, "R3 cleared by write", v[7], 0);

    // R2 bit-7 alias
    wr(8'h80, 8'h80, 1'b0);
    rd(1'b0, v);
    chk(v[7:6] == 2'b11, "R2 mode bits via sel=0", v[7:6], 3);
    rd(1'b1, v);
    chk(v[7] == 1'b0, "R2 framing flag untouched", v[7], 0);
    wr(8'h80, 8'h80, 1'b1);
    rd(1'b1, v);
    chk(v[7] == 1'b1, "R2 framing flag set via sel=1", v[7], 1);
    rd(1'b0, v);
    chk(v[7] == 1'b1, "R2 mode high bit kept", v[7], 1);
    wr(8'h80, 8'h00, 1'b1);

    // R6 single-tick glitch on a data bit, then a glitch start bit
    wr(8'hFF, 8'h50, 1'b0);
    send(8'h6B, 1'b0, 1'b0, 1'b1, 1'b1);
    chk(rx_byte == 8'h6B, "R6 majority vote", rx_byte, 8'h6B);
    wr(8'h01, 8'h00, 1'b0);
    @(negedge clk); rxd_i = 1'b0;
    repeat (3) @(negedge clk); rxd_i = 1'b1;
    repeat (200) @(negedge clk);
    rd(1'b0, v);
    chk(v[0] == 1'b0, "R6 glitch start dropped", v[0], 0);
    send(8'hC4, 1'b0, 1'b0, 1'b1, 1'b0);
    chk(rx_byte == 8'hC4, "R6 receive after glitch", rx_byte, 8'hC4);

    // R9 receive disabled
    wr(8'hFF, 8'h40, 1'b0);
    send(8'h3A, 1'b0, 1'b0, 1'b1, 1'b0);
    rd(1'b0, v);
    chk(v[0] == 1'b0 && rx_byte == 8'hC4, "R9 no reception", {v[0], rx_byte}, 9'h0C4);

    // R4 R5 8-bit transmit with an ignored second write
    wr(8'hFF, 8'h40, 1'b0);
    tx_byte = 8'h4D;
    txcap(10, 1'b1, bits, tiv);
    chk(bits[9:0] == {1'b1, 8'h4D, 1'b0}, "R4 8-bit frame, write while busy ignored",
        bits[9:0], {1'b1, 8'h4D, 1'b0});
    chk(tiv[8] == 1'b0 && tiv[9] == 1'b1, "R5 flag at stop start", tiv[9:8], 2);

    // R4 R5 9-bit transmit, ninth bit 1
    wr(8'hFF, 8'hC8, 1'b0);
    tx_byte = 8'hB6;
    txcap(11, 1'b0, bits, tiv);
    chk(bits == {1'b1, 1'b1, 8'hB6, 1'b0}, "R4 9-bit frame", bits, {1'b1, 1'b1, 8'hB6, 1'b0});
    chk(tiv[9] == 1'b0 && tiv[10] == 1'b1, "R5 9-bit flag at stop", tiv[10:9], 2);

    // R12 mode 10 waits for its own tick
    wr(8'hFF, 8'h80, 1'b0);
    tick_fix = 1'b0;
    @(negedge clk); tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    repeat (40) @(negedge clk);
    chk(txd == 1'b0, "R12 held in start bit", txd, 0);
    tick_fix = 1'b1;
    repeat (200) @(negedge clk);
    rd(1'b0, v);
    chk(txd == 1'b1 && v[1] == 1'b1, "R12 frame finished", {txd, v[1]}, 3);

    // R10 shift-mode transmit
    wr(8'hFF, 8'h00, 1'b0);
    tx_byte = 8'hB2;
    n = 0; got = '0; oe_ok = 1; prev = txd;
    @(negedge clk); tx_wr = 1'b1;
    @(negedge clk); tx_wr = 1'b0;
    for (int c = 0; c < 60; c++) begin
      if (prev && !txd && !rxd_oe) oe_ok = 0;
      if (!prev && txd && n < 8) begin got[n] = rxd_o; n++; end
      prev = txd;
      @(negedge clk);
    end
    chk(n == 8 && got == 8'hB2, "R10 shifted byte", got, 8'hB2);
    chk(oe_ok, "R10 output enable", oe_ok, 1);
    rd(1'b0, v);
    chk(v[1] == 1'b1 && !rxd_oe, "R5 shift-mode transmit flag", {v[1], rxd_oe}, 2);

    // R11 shift-mode receive
    wr(8'hFF, 8'h10, 1'b0);
    n = 0; prev = 1'b1;
    for (int c = 0; c < 60; c++) begin
      if (prev && !txd && n < 8) begin rxd_i = 8'h5C >> n; n++; end
      prev = txd;
      @(negedge clk);
    end
    rxd_i = 1'b1;
    rd(1'b0, v);
    chk(v[0] == 1'b1 && rx_byte == 8'h5C, "R11 shift receive", {v[0], rx_byte}, 9'h15C);
    oe_ok = 1;
    for (int c = 0; c < 20; c++) begin
      if (!txd) oe_ok = 0;
      @(negedge clk);
    end
    chk(oe_ok, "R11 no restart while flag set", oe_ok, 1);
    wr(8'hFF, 8'h00, 1'b0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule